// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a circular list of transmit descriptors kept in host memory. Each descriptor is two 32-bit words: a control word and a buffer pointer. Software programs an aligned ring base, a ring length and two mode bits. After it has handed descriptors to hardware by setting their ownership bit, it pulses a kick input. The walker reads each control word over a word-wide memory port. For every descriptor that hardware owns, it fetches the buffer pointer and presents a buffer request to a downstream data mover: address, byte count, and the packet boundary and checksum bits. Once the mover accepts the request, the walker writes the control word back with ownership handed to software.

The walker stops at the first descriptor that software still owns, and then raises a completion interrupt. In drain mode the interrupt is held until the transmit FIFO reports empty. A packet whose descriptors run out before one marked as its last raises a sticky error. A synchronous software reset puts the displacement back to entry zero and clears all pending and interrupt state.

Top module: `txring_walker`

## Requirements
- R1: After the asynchronous reset is released, the displacement is 0. There are no memory or buffer requests, and the pending flag and both interrupts are low.
- R2: While dma_en is low, the walker starts no memory access. A pending kick stays pending until dma_en rises.
- R3: A control word is read at byte address {ring_base, disp, 3'b000}. The buffer pointer of the same descriptor is read at that address plus 4.
- R4: The displacement advances by one per completed descriptor. After entry 16*(ring_size+1)-1 it wraps to 0, so ring_size 0..15 selects 16..256 entries.
- R5: A kick sets the pending flag. The flag clears itself in the cycle the idle walker, with dma_en high, accepts it.
- R6: When the walker reads a control word whose bit 31 is 0, it stops without advancing the displacement. It does not resume for descriptors handed over later until a new kick arrives.
- R7: The buffer request carries the pointer word as address and control bits 13:0 as length. Bit 30 drives the first-of-packet flag, bit 29 the last-of-packet flag and bit 28 the checksum flag. The request stays asserted, with stable fields, until buf_ack.
- R8: After each accepted buffer request, the control word is written back to its own address with bit 31 cleared and all other bits unchanged.
- R9: pkt_sent pulses for exactly one cycle for each written-back descriptor whose bit 29 is set.
- R10: With drain_mode 0, irq_all sets when the walker stops after handling at least one descriptor. A kick clears it.
- R11: With drain_mode 1, irq_all sets only once fifo_empty is high as well.
- R12: If an unowned control word is read while a packet has started but its last descriptor has not been seen, irq_eop_err sets and stays set.
- R13: A sw_rst pulse returns the displacement to 0 and clears the pending flag, both interrupts and the walker state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| dma_en | input | 1 | Permits descriptor fetching |
| drain_mode | input | 1 | 1: irq_all also waits for fifo_empty |
| ring_base | input | 21 | 2 KB aligned ring base, address bits 31:11 |
| ring_size | input | 4 | Ring length code, 16*(code+1) entries |
| kick | input | 1 | Transmit-pending command pulse |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write-back, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| buf_req | output | 1 | Buffer fetch request |
| buf_addr | output | 32 | Buffer address |
| buf_len | output | 14 | Buffer byte count |
| buf_sop | output | 1 | First descriptor of packet |
| buf_eop | output | 1 | Last descriptor of packet |
| buf_csum | output | 1 | Checksum requested |
| buf_ack | input | 1 | Buffer request accepted |
| kick_pend | output | 1 | Pending command not yet accepted |
| disp | output | 8 | Current descriptor displacement |
| pkt_sent | output | 1 | One-cycle pulse per finished packet |
| irq_all | output | 1 | Walk complete interrupt |
| irq_eop_err | output | 1 | Missing last-of-packet error |

## Verification
Several rules are checked on every cycle by properties:
- no fetch starts from rest while DMA is disabled;
- the pending flag clears when it is accepted;
- the displacement stays inside the programmed ring;
- buffer requests are held steady until accepted;
- every acceptance is followed by a write-back that has the ownership bit clear;
- pkt_sent never lasts more than one cycle;
- drain-mode completions coincide with an empty FIFO;
- the error only rises after an unowned word is read.

Other behaviour only the scenarios can show. This covers the exact address sequence, field decoding, and write-back contents that match the posted descriptors, together with the wrap position for each ring size. It also covers stopping at an unowned entry without advancing, staying idle over newly posted work until a kick, and the effect of software reset.

// File: rtl/txring_walker.sv
module txring_walker #(
  parameter int BASE_W = 21,
  parameter int DISP_W = 8,
  parameter int SZ_W   = 4,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              dma_en,
  input  logic              drain_mode,
  input  logic [BASE_W-1:0] ring_base,
  input  logic [SZ_W-1:0]   ring_size,
  input  logic              kick,
  input  logic              fifo_empty,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BASE_W+DISP_W+2:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              buf_req,
  output logic [31:0]       buf_addr,
  output logic [LEN_W-1:0]  buf_len,
  output logic              buf_sop,
  output logic              buf_eop,
  output logic              buf_csum,
  input  logic              buf_ack,
  output logic              kick_pend,
  output logic [DISP_W-1:0] disp,
  output logic              pkt_sent,
  output logic              irq_all,
  output logic              irq_eop_err
);
  localparam int LOW_W = DISP_W - SZ_W;

  typedef enum logic [2:0] {S_IDLE, S_FLAG, S_ADDR, S_BUF, S_WB, S_FIN} st_t;

  st_t         st;
  logic [31:0] flags;
  logic [31:0] baddr;
  logic        in_pkt;
  logic        did;

  logic [DISP_W-1:0] last_ent;
  assign last_ent = {ring_size, {LOW_W{1'b1}}};

  assign mem_req   = (st == S_FLAG) || (st == S_ADDR) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = {ring_base, disp, (st == S_ADDR), 2'b00};
  assign mem_wdata = {1'b0, flags[30:0]};

  assign buf_req  = (st == S_BUF);
  assign buf_addr = baddr;
  assign buf_len  = flags[LEN_W-1:0];
  assign buf_sop  = flags[30];
  assign buf_eop  = flags[29];
  assign buf_csum = flags[28];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; flags <= '0; baddr <= '0; in_pkt <= 1'b0; did <= 1'b0;
      kick_pend <= 1'b0; disp <= '0; pkt_sent <= 1'b0; irq_all <= 1'b0; irq_eop_err <= 1'b0;
    end else if (sw_rst) begin
      st <= S_IDLE; flags <= '0; baddr <= '0; in_pkt <= 1'b0; did <= 1'b0;
      kick_pend <= 1'b0; disp <= '0; pkt_sent <= 1'b0; irq_all <= 1'b0; irq_eop_err <= 1'b0;
    end else begin
      pkt_sent  <= 1'b0;
      kick_pend <= kick_pend | kick;
      irq_all   <= irq_all & ~kick;
      case (st)
        S_IDLE: if (kick_pend && dma_en) begin
          kick_pend <= kick;
          did       <= 1'b0;
          st        <= S_FLAG;
        end
        S_FLAG: if (mem_ack) begin
          if (mem_rdata[31]) begin
            flags <= mem_rdata;
            st    <= S_ADDR;
          end else begin
            if (in_pkt) irq_eop_err <= 1'b1;
            in_pkt <= 1'b0;
            st     <= S_FIN;
          end
        end
        S_ADDR: if (mem_ack) begin
          baddr <= mem_rdata;
          st    <= S_BUF;
        end
        S_BUF: if (buf_ack) st <= S_WB;
        S_WB: if (mem_ack) begin
          disp     <= (disp == last_ent) ? '0 : disp + 1'b1;
          in_pkt   <= ~flags[29];
          pkt_sent <= flags[29];
          did      <= 1'b1;
          st       <= dma_en ? S_FLAG : S_IDLE;
        end
        S_FIN: if (!drain_mode || fifo_empty) begin
          if (did) irq_all <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_no_fetch_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !buf_req && !dma_en) |=> !mem_req);

  a_r4_disp_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (disp <= last_ent));

  a_r5_pend_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && kick_pend && dma_en && !kick) |=> !kick_pend);

  a_r7_buf_req_held: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (buf_req && !buf_ack) |=> (buf_req && $stable(buf_addr) && $stable(buf_len) && $stable(buf_eop)));

  a_r8_writeback_follows: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (buf_req && buf_ack) |=> (mem_req && mem_we && !mem_wdata[31]));

  a_r9_sent_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent |=> !pkt_sent);

  a_r11_drain_waits_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_all) && $past(drain_mode)) |-> $past(fifo_empty));

  a_r12_err_after_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eop_err) |-> $past(mem_req && !mem_we && mem_ack && !mem_rdata[31]));
endmodule

// File: tb/txring_walker_tb_top.sv
module txring_walker_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sw_rst, dma_en, drain_mode, kick, fifo_empty;
  logic [20:0] ring_base;
  logic [3:0]  ring_size;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        buf_req, buf_sop, buf_eop, buf_csum, buf_ack;
  logic [31:0] buf_addr;
  logic [13:0] buf_len;
  logic        kick_pend, pkt_sent, irq_all, irq_eop_err;
  logic [7:0]  disp;

  txring_walker dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .dma_en(dma_en), .drain_mode(drain_mode),
    .ring_base(ring_base), .ring_size(ring_size), .kick(kick), .fifo_empty(fifo_empty),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_req(buf_req), .buf_addr(buf_addr),
    .buf_len(buf_len), .buf_sop(buf_sop), .buf_eop(buf_eop), .buf_csum(buf_csum),
    .buf_ack(buf_ack), .kick_pend(kick_pend), .disp(disp), .pkt_sent(pkt_sent),
    .irq_all(irq_all), .irq_eop_err(irq_eop_err));

  logic [31:0] mem [0:511];
  int n_checks = 0, n_fail = 0;
  int addr_err = 0, req_seen = 0, sent_cnt = 0, log_n = 0, cyc = 0;
  logic [31:0] log_addr [0:63];
  logic [16:0] log_fld  [0:63];

  int          exp_n, ring_n, cur, eop_cnt;
  bit          prev_eop;
  logic [31:0] exp_flags [0:63];
  logic [31:0] exp_addr  [0:63];
  int          exp_idx   [0:63];

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; buf_ack = 1'b0;
    end else begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        req_seen++;
        if (mem_addr[31:11] != ring_base) addr_err++;
        if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[10:2]];
        mem_ack = 1'b1;
      end
      if (buf_ack) buf_ack = 1'b0;
      else if (buf_req && ($urandom % 3 != 0)) begin
        if (log_n < 64) begin
          log_addr[log_n] = buf_addr;
          log_fld[log_n]  = {buf_sop, buf_eop, buf_csum, buf_len};
        end
        log_n++;
        buf_ack = 1'b1;
      end
      if (pkt_sent) sent_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_flags(input bit sop, input bit eop, input bit cs,
                                           input logic [13:0] len, input logic [12:0] mid);
    return {1'b1, sop, eop, cs, mid[11:0], 2'b00, len};
  endfunction

  task automatic prep(input int n, input bit force_eop);
    exp_n = n; eop_cnt = 0;
    for (int i = 0; i < n; i++) begin
      int d = (cur + i) % ring_n;
      bit e = (i == n - 1) ? force_eop : bit'($urandom % 2);
      exp_flags[i] = mk_flags(prev_eop, e, bit'($urandom % 2), 14'($urandom), 13'($urandom));
      exp_addr[i]  = $urandom;
      exp_idx[i]   = d;
      if (e) eop_cnt++;
      prev_eop = e;
      mem[2*d]     = exp_flags[i];
      mem[2*d + 1] = exp_addr[i];
    end
    mem[2*((cur + n) % ring_n)] = $urandom & 32'h7fff_ffff;
    log_n = 0; sent_cnt = 0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n * 16 + 40) @(negedge clk);
  endtask

  task automatic verify(input string tag_r10, input bit exp_irq, input bit exp_err);
    check(log_n == exp_n, "R7", "buffer request count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < 64; i++) begin
      logic [16:0] ef = {exp_flags[i][30:28], exp_flags[i][13:0]};
      check(log_addr[i] == exp_addr[i] && log_fld[i] == ef, "R7", "buffer request fields",
            {log_fld[i], log_addr[i]}, {ef, exp_addr[i]});
      check(mem[2*exp_idx[i]] == (exp_flags[i] & 32'h7fff_ffff), "R8", "written-back word",
            mem[2*exp_idx[i]], exp_flags[i] & 32'h7fff_ffff);
    end
    cur = (cur + exp_n) % ring_n;
    check(disp == 8'(cur), "R4", "displacement after walk", disp, cur);
    check(sent_cnt == eop_cnt, "R9", "pkt_sent pulses", sent_cnt, eop_cnt);
    check(irq_all == exp_irq, tag_r10, "irq_all", irq_all, exp_irq);
    check(irq_eop_err == exp_err, "R12", "irq_eop_err", irq_eop_err, exp_err);
    check(addr_err == 0, "R3", "address outside ring base", addr_err, 0);
  endtask

  task automatic soft_reset();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    cur = 0; prev_eop = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    rst_n = 1'b0; sw_rst = 1'b0; dma_en = 1'b0; drain_mode = 1'b0; kick = 1'b0;
    fifo_empty = 1'b1; ring_base = 21'h0a5c3; ring_size = 4'd0;
    mem_rdata = '0;
    ring_n = 16; cur = 0; prev_eop = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(disp == 0 && !mem_req && !buf_req && !kick_pend && !irq_all && !irq_eop_err,
          "R1", "state after reset", {disp, mem_req, buf_req, kick_pend, irq_all, irq_eop_err}, 0);

    // R2 kick while disabled stays pending, nothing fetched
    prep(12, 1'b1);
    req_seen = 0;
    pulse_kick();
    repeat (30) @(negedge clk);
    check(req_seen == 0, "R2", "memory accesses while disabled", req_seen, 0);
    check(kick_pend == 1'b1, "R2", "kick held pending", kick_pend, 1);
    dma_en = 1'b1;
    repeat (2) @(negedge clk);
    check(kick_pend == 1'b0, "R5", "pending cleared on acceptance", kick_pend, 0);
    settle(12);
    verify("R10", 1'b1, 1'b0);

    // R6 post more work without kicking: nothing happens
    prep(8, 1'b1);
    repeat (60) @(negedge clk);
    check(log_n == 0, "R6", "no requests without kick", log_n, 0);
    check(disp == 8'(cur), "R6", "displacement held at unowned entry", disp, cur);
    pulse_kick();
    check(irq_all == 1'b0, "R10", "irq_all cleared by kick", irq_all, 0);
    settle(8);
    verify("R10", 1'b1, 1'b0); // wraps past entry 15

    // R11 drain mode waits for FIFO empty
    drain_mode = 1'b1; fifo_empty = 1'b0;
    prep(5, 1'b1);
    pulse_kick();
    settle(5);
    check(irq_all == 1'b0, "R11", "irq_all held while FIFO not empty", irq_all, 0);
    fifo_empty = 1'b1;
    repeat (3) @(negedge clk);
    verify("R11", 1'b1, 1'b0);
    drain_mode = 1'b0;

    // R12 packet without last descriptor
    prep(3, 1'b0);
    pulse_kick();
    settle(3);
    verify("R10", 1'b1, 1'b1);
    prev_eop = 1'b1;

    // R13 software reset
    soft_reset();
    @(negedge clk);
    check(disp == 0 && !irq_all && !irq_eop_err && !kick_pend, "R13", "state after sw_rst",
          {disp, irq_all, irq_eop_err, kick_pend}, 0);

    // random batches on a 32-entry ring, wrapping at entry 31
    ring_size = 4'd1; ring_n = 32;
    for (int b = 0; b < 8; b++) begin
      prep(1 + int'($urandom % 10), 1'b1);
      pulse_kick();
      settle(10);
      verify("R10", 1'b1, 1'b0);
    end

    // largest ring: wrap after entry 255
    soft_reset();
    ring_size = 4'd15; ring_n = 256;
    for (int b = 0; b < 5; b++) begin
      prep(60, 1'b1);
      pulse_kick();
      settle(60);
      verify("R10", 1'b1, 1'b0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule